// File: doc/BRIEF.md
# Bus-Watch Debug Trigger Unit

This block sits beside a processor's bus interface. It watches every bus access, meaning the address and whether the access is a read or a write. It compares the address against two reference values. When a configured trigger condition occurs, it ends a capture run and can ask the CPU to halt. While a run is active, the addresses of accesses are written into a small trace buffer. Software can read that buffer afterwards, with index 0 returning the oldest entry.

An 8-bit control register sets the block up. Bit 7 turns the unit on. Bit 6 arms a run. Bit 5 picks the type of break request: 1 gives a tag break and 0 gives a force break. Bit 4 allows break requests at all. Bits 3 and 2 are the direction value and the direction enable for comparator A. Bits 1 and 0 are the same pair for comparator B. A direction value of 1 means reads only and 0 means writes only.

Two inputs set the trace mode and the trigger source.
- **End trace** records continuously and stops at the trigger.
- **Begin trace** starts recording at the trigger and stops once the buffer is full.
- The trigger source is either comparator A alone, or A or B.

A register write takes priority: any bus access in the same cycle as a write is not observed.

Top module: `bus_trigger_unit`

## Requirements
- R1: After reset the control register reads 0x00, `armed` is 0, the trace count is 0 and no break is driven. `reg_rdata` always returns the current register, with bit 6 showing the live arm state.
- R2: A write while `secure_i` is 1 leaves bit 7 (enable) at 0. Because enable is 0, the arm bit also stays 0.
- R3: Writing bit 6 = 1 with the unit enabled sets both the arm bit and `armed`, and starts a fresh run with an empty buffer. Writing 0 to bit 6 or to bit 7 stops the run at once, and no later access can raise a break.
- R4: Comparator A hits when `bus_valid` is 1 and `bus_addr` equals `cmp_a_ref`. If bit 2 is 1, bit 3 must also equal `bus_rd` (1 for read, 0 for write). If bit 2 is 0, `bus_rd` is ignored.
- R5: Comparator B follows the same rule with bits 1 and 0. B can only trigger when `trig_either_i` is 1 (A or B). When it is 0, only comparator A triggers.
- R6: With bit 4 at 0, `brk_tag` and `brk_force` stay 0 whatever bit 5 holds. The run still completes and the buffer still fills.
- R7: A break is a single-cycle combinational pulse, given in the same cycle as the completing access. Bit 5 = 1 drives `brk_tag` and bit 5 = 0 drives `brk_force`. The two are never high together.
- R8: In end trace (`trace_begin_i` = 0), every armed access is stored, and once the buffer is full the oldest entry is overwritten. The triggering access is stored last and completes the run, and its cycle carries the break. Index 0 reads the oldest entry.
- R9: In begin trace (`trace_begin_i` = 1), nothing is stored before the trigger. The triggering access becomes entry 0. The access that makes the count reach DEPTH completes the run and carries the break. After that the count stays at DEPTH.
- R10: Completing a run clears the arm bit and `armed` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| secure_i | input | 1 | Secure state; blocks enabling |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| cmp_a_ref | input | 16 | Comparator A reference address |
| cmp_b_ref | input | 16 | Comparator B reference address |
| trace_begin_i | input | 1 | 1 = begin trace, 0 = end trace |
| trig_either_i | input | 1 | 1 = A or B triggers, 0 = A only |
| bus_valid | input | 1 | A bus access occurs this cycle |
| bus_addr | input | 16 | Access address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| armed | output | 1 | Run in progress |
| brk_tag | output | 1 | Tag-type break request |
| brk_force | output | 1 | Force-type break request |
| fifo_rd_idx | input | 3 | Trace entry index, 0 = oldest |
| fifo_rd_data | output | 16 | Trace entry at that index |
| fifo_count | output | 4 | Valid trace entries |

## Verification
Break requests are combinational from the access, so the bench drives each access just after a falling edge and samples `brk_tag` and `brk_force` before the next rising edge. A register write shows on `reg_rdata` and `armed` one cycle later, and the bench reads them just after that edge. The end of a run clears `armed` at the edge that ends the completing access, and the new trace count and entries are visible there as well. The bench samples all of these one time unit after that edge.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic en;
        logic arm;
        logic tag_sel;
        logic brk_en;
        logic rwa_val;
        logic rwa_en;
        logic rwb_val;
        logic rwb_en;
    } bt_ctrl_t;

    typedef enum logic {
        TRACE_END   = 1'b0,
        TRACE_BEGIN = 1'b1
    } bt_trace_e;

    // Direction qualifier: passes when unqualified or when the access kind matches.
    function automatic logic bt_dir_ok(input logic qual_en, input logic want_rd,
                                       input logic is_rd);
        return !qual_en || (want_rd == is_rd);
    endfunction

endpackage

// File: rtl/bt_ctrl_reg.sv
module bt_ctrl_reg
    import bt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                secure_i,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    input  logic                run_done,
    output bt_ctrl_t            ctrl_o,
    output logic                start_o
);
    bt_ctrl_t ctrl_q;
    bt_ctrl_t wr_ctrl;
    logic     en_ok;

    always_comb begin
        wr_ctrl = bt_ctrl_t'(wr_data);
        en_ok   = wr_ctrl.en & ~secure_i;
        start_o = wr_en & en_ok & wr_ctrl.arm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q     <= wr_ctrl;
            ctrl_q.en  <= en_ok;
            ctrl_q.arm <= wr_ctrl.arm & en_ok;
        end else if (run_done) begin
            ctrl_q.arm <= 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/bt_comparator.sv
module bt_comparator
    import bt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] ref_i,
    input  logic              is_rd_i,
    input  logic              qual_en_i,
    input  logic              want_rd_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = valid_i && (addr_i == ref_i) && bt_dir_ok(qual_en_i, want_rd_i, is_rd_i);
    end
endmodule

// File: rtl/bt_trace_fifo.sv
module bt_trace_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic [DW-1:0] rd_data
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] wptr;
    logic [IW-1:0] oldest;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr  <= '0;
            count <= '0;
        end else if (push) begin
            wptr <= wptr + 1'b1;
            if (count != FULL) count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[wptr] <= din;
    end

    always_comb begin
        oldest  = (count == FULL) ? wptr : '0;
        rd_data = mem[oldest + rd_idx];
    end
endmodule

// File: rtl/bus_trigger_unit.sv
module bus_trigger_unit
    import bt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = IW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              secure_i,
    input  logic              reg_we,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] cmp_a_ref,
    input  logic [ADDR_W-1:0] cmp_b_ref,
    input  logic              trace_begin_i,
    input  logic              trig_either_i,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic              armed,
    output logic              brk_tag,
    output logic              brk_force,
    input  logic [IW-1:0]     fifo_rd_idx,
    output logic [ADDR_W-1:0] fifo_rd_data,
    output logic [CW-1:0]     fifo_count
);
    localparam int NCMP = 2;

    bt_ctrl_t  ctrl;
    bt_trace_e mode;
    logic      start_run, run_done, live, trig, push, started_q, brk_fire;
    logic [NCMP-1:0]             hit;
    logic [NCMP-1:0][ADDR_W-1:0] refs;
    logic [NCMP-1:0]             qual_en, want_rd;

    bt_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .secure_i (secure_i),
        .wr_en    (reg_we),
        .wr_data  (reg_wdata),
        .run_done (run_done),
        .ctrl_o   (ctrl),
        .start_o  (start_run)
    );

    always_comb begin
        refs[0]    = cmp_a_ref;
        refs[1]    = cmp_b_ref;
        qual_en[0] = ctrl.rwa_en;
        want_rd[0] = ctrl.rwa_val;
        qual_en[1] = ctrl.rwb_en;
        want_rd[1] = ctrl.rwb_val;
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        bt_comparator #(.ADDR_W(ADDR_W)) u_cmp (
            .valid_i   (bus_valid),
            .addr_i    (bus_addr),
            .ref_i     (refs[g]),
            .is_rd_i   (bus_rd),
            .qual_en_i (qual_en[g]),
            .want_rd_i (want_rd[g]),
            .hit_o     (hit[g])
        );
    end

    always_comb begin
        mode = bt_trace_e'(trace_begin_i);
        trig = hit[0] | (trig_either_i & hit[1]);
        live = ctrl.arm & ~reg_we & bus_valid;
        push = live & ((mode == TRACE_END) | started_q | trig);
        if (mode == TRACE_END) run_done = live & trig;
        else                   run_done = push & (fifo_count == CW'(DEPTH - 1));
        brk_fire  = run_done & ctrl.brk_en;
        brk_tag   = brk_fire & ctrl.tag_sel;
        brk_force = brk_fire & ~ctrl.tag_sel;
    end

    always_ff @(posedge clk) begin
        if (rst || start_run)                          started_q <= 1'b0;
        else if (live && trig && mode == TRACE_BEGIN)  started_q <= 1'b1;
    end

    bt_trace_fifo #(.DEPTH(DEPTH), .DW(ADDR_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .clear   (start_run),
        .push    (push),
        .din     (bus_addr),
        .rd_idx  (fifo_rd_idx),
        .count   (fifo_count),
        .rd_data (fifo_rd_data)
    );

    assign reg_rdata = ctrl;
    assign armed     = ctrl.arm;
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          secure_i,
    input logic          reg_we,
    input logic [7:0]    reg_rdata,
    input logic          armed,
    input logic          brk_tag,
    input logic          brk_force,
    input logic [CW-1:0] fifo_count
);
    assert_secure_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && secure_i) |=> !reg_rdata[7]);

    assert_arm_from_write_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(reg_we));

    assert_break_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        (brk_tag || brk_force) |-> (armed && reg_rdata[4]));

    assert_break_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(brk_tag && brk_force));

    assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    assert_done_disarms_R10: assert property (@(posedge clk) disable iff (rst)
        (brk_tag || brk_force) |=> !armed);
endmodule

bind bus_trigger_unit bt_checker #(.DEPTH(DEPTH)) u_bt_checker (
    .clk        (clk),
    .rst        (rst),
    .secure_i   (secure_i),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .armed      (armed),
    .brk_tag    (brk_tag),
    .brk_force  (brk_force),
    .fifo_count (fifo_count)
);

// File: tb/bus_trigger_unit_bench.sv
`timescale 1ns/1ps
module bus_trigger_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        secure_i, reg_we, trace_begin_i, trig_either_i;
    logic        bus_valid, bus_rd;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [15:0] cmp_a_ref, cmp_b_ref, bus_addr, fifo_rd_data;
    logic        armed, brk_tag, brk_force;
    logic [2:0]  fifo_rd_idx;
    logic [3:0]  fifo_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bus_trigger_unit u_bus_trigger_unit (.*);

    // ctrl[28:21] either[20] addr[19:4] rd[3] exp_tag[2] exp_force[1] exp_done[0]
    localparam int NV = 10;
    localparam logic [28:0] VEC [NV] = '{
        {8'hD0, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1},   // R7 force
        {8'hF0, 1'b0, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b1},   // R7 tag
        {8'hD4, 1'b0, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0},   // R4 write-only, read miss
        {8'hDC, 1'b0, 16'h1234, 1'b1, 1'b0, 1'b1, 1'b1},   // R4 read-only hit
        {8'hDC, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0},   // R4 read-only, write miss
        {8'hD0, 1'b0, 16'h5678, 1'b0, 1'b0, 1'b0, 1'b0},   // R5 B ignored in A-only
        {8'hD0, 1'b1, 16'h5678, 1'b0, 1'b0, 1'b1, 1'b1},   // R5 B hit in A-or-B
        {8'hD1, 1'b1, 16'h5678, 1'b1, 1'b0, 1'b0, 1'b0},   // R5 B write-only, read miss
        {8'hC0, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1},   // R6 no break, run ends
        {8'hE0, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1}    // R6 tag select without enable
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    // drives one access; samples breaks before the edge, state after it
    task automatic acc(input logic [15:0] a, input logic r, output logic t, output logic f);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_rd = r;
        #1;
        t = brk_tag; f = brk_force;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic t, f;
        rst = 1'b1; secure_i = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        trace_begin_i = 1'b0; trig_either_i = 1'b0;
        bus_valid = 1'b0; bus_rd = 1'b0; bus_addr = '0; fifo_rd_idx = '0;
        cmp_a_ref = 16'h1234; cmp_b_ref = 16'h5678;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk("R1 reset reg", reg_rdata, 8'h00);
        chk("R1 reset armed", armed, 0);
        chk("R1 reset count", fifo_count, 0);
        chk("R1 reset brk", {brk_tag, brk_force}, 0);

        // vector table: comparator, direction, trigger source, break type
        for (int i = 0; i < NV; i++) begin
            trig_either_i = VEC[i][20];
            wr(VEC[i][28:21]);
            chk("R3 armed after write", armed, 1);
            acc(VEC[i][19:4], VEC[i][3], t, f);
            if ({t, f} !== VEC[i][2:1])
                $display("  vector %0d (R4/R5/R6/R7)", i);
            chk("R4/R5/R6/R7 break", {t, f}, VEC[i][2:1]);
            chk("R10 armed after access", armed, !VEC[i][0]);
        end
        trig_either_i = 1'b0;

        // R1 readback of non-arm bits after completion
        wr(8'hAF);
        chk("R1 readback", reg_rdata, 8'hAF);

        // R2 secure blocks enable
        secure_i = 1'b1;
        wr(8'hD0);
        chk("R2 enable blocked", reg_rdata, 8'h10);
        chk("R2 not armed", armed, 0);
        acc(16'h1234, 1'b0, t, f);
        chk("R2 no break", {t, f}, 0);
        secure_i = 1'b0;

        // R3 writing 0 to arm stops the run
        wr(8'hD0);
        wr(8'h90);
        chk("R3 arm cleared", armed, 0);
        acc(16'h1234, 1'b0, t, f);
        chk("R3 no break after disarm", {t, f}, 0);
        // R3 writing 0 to enable stops the run
        wr(8'hD0);
        wr(8'h50);
        chk("R3 enable off disarms", reg_rdata, 8'h10);

        // R8 end trace: wraparound, trigger stored last
        trace_begin_i = 1'b0;
        wr(8'hD0);
        for (int k = 0; k < 10; k++) begin
            acc(16'h1000 + 16'(k), 1'b0, t, f);
            if (t | f) chk("R8 early break", {t, f}, 0);
        end
        chk("R8 still armed", armed, 1);
        acc(16'h1234, 1'b0, t, f);
        chk("R8 break at trigger", {t, f}, 2'b01);
        chk("R8 count", fifo_count, 8);
        fifo_rd_idx = 3'd0; #1;
        chk("R8 oldest entry", fifo_rd_data, 16'h1003);
        fifo_rd_idx = 3'd7; #1;
        chk("R8 trigger entry last", fifo_rd_data, 16'h1234);
        chk("R10 end trace disarmed", armed, 0);

        // R9 begin trace: tag break at full
        trace_begin_i = 1'b1;
        wr(8'hF0);
        acc(16'h2000, 1'b0, t, f);
        chk("R9 nothing before trigger", fifo_count, 0);
        acc(16'h1234, 1'b0, t, f);
        chk("R9 no break at trigger", {t, f}, 0);
        chk("R9 trigger stored", fifo_count, 1);
        for (int k = 1; k < 7; k++) begin
            acc(16'h3000 + 16'(k), 1'b1, t, f);
            if (t | f) chk("R9 early break", {t, f}, 0);
        end
        chk("R9 count before full", fifo_count, 7);
        acc(16'h3007, 1'b1, t, f);
        chk("R9 tag break at full", {t, f}, 2'b10);
        chk("R9 count full", fifo_count, 8);
        chk("R10 begin trace disarmed", armed, 0);
        fifo_rd_idx = 3'd0; #1;
        chk("R9 first entry is trigger", fifo_rd_data, 16'h1234);
        fifo_rd_idx = 3'd7; #1;
        chk("R9 last entry", fifo_rd_data, 16'h3007);
        acc(16'h1234, 1'b0, t, f);
        chk("R9 no capture after run", fifo_count, 8);
        chk("R9 no break after run", {t, f}, 0);

        // R6 begin trace without break enable still fills
        wr(8'hC0);
        for (int k = 0; k < 8; k++) begin
            acc(16'h1234, 1'b0, t, f);
            if (t | f) chk("R6 break while disabled", {t, f}, 0);
        end
        chk("R6 filled", fifo_count, 8);
        chk("R6 run completed", armed, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule